// File: doc/BRIEF.md
# SPI Status and Interrupt Unit

This block keeps the status flags of a serial peripheral and turns them into interrupt requests. A separate transfer engine reports what happens on the wire as single-cycle pulses (a transmit byte left the buffer, the buffer was reloaded, a byte arrived, the receive buffer was read, an overrun, a mode fault, a CRC mismatch, a serial clock sampling edge) and as a busy level. The unit stores these as flags and exposes them through a byte-wide status register on a simple register bus.

An interrupt-enable register sits beside the status register. One level interrupt line covers all enabled sources, and the three error flags share a single enable. A separate wake request leaves the low-power halt state, and only the wakeup flag drives it. The overrun, mode-fault, CRC-error and wakeup flags stay set until software writes a zero to their bit. Writing a one leaves them as they are.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset the status register reads 0x02 while `busy_i` is low, the enable register reads 0x00, and `irq_o` and `wake_o` are low.
- R2: A pulse on `ovr_i`, `modf_i` or `crc_err_i` sets status bit 6, 5 or 4 in turn. The bit then stays set, whatever the inputs do, until software clears it.
- R3: A write to the status address (`addr_i` = 0) clears each of bits 6 to 3 whose written value is 0, and leaves each whose written value is 1 unchanged.
- R4: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: Status bit 3 (wakeup) is set only in a cycle where `sck_edge_i`, `halt_i` and `slave_i` are all high. A sampling edge while not halted, or while in master mode, leaves it clear.
- R6: Status bit 7 reads `busy_i` and bit 2 always reads 0. A write to the status address does not change bits 7, 2, 1 or 0.
- R7: Status bit 1 (transmit empty) is set by `txe_set_i` and cleared by `tx_load_i`. Bit 0 (receive full) is set by `rx_done_i` and cleared by `rx_read_i`. If both arrive in one cycle, the set wins.
- R8: A write to the enable address (`addr_i` = 1) stores bits 7 to 4: transmit enable, receive enable, error enable and wakeup enable. Bits 3 to 0 always read 0.
- R9: `irq_o` is high exactly while (bit1 and tx enable) or (bit0 and rx enable) or (bit3 and wakeup enable) or (error enable and any of bits 6, 5, 4) holds.
- R10: `wake_o` is high exactly while the wakeup flag and the wakeup enable are both set. No other source drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 status, 1 interrupt enable |
| wr_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| busy_i | input | 1 | Engine busy level |
| txe_set_i | input | 1 | Transmit buffer emptied pulse |
| tx_load_i | input | 1 | Transmit buffer loaded pulse |
| rx_done_i | input | 1 | Byte received pulse |
| rx_read_i | input | 1 | Receive buffer read pulse |
| ovr_i | input | 1 | Overrun pulse |
| modf_i | input | 1 | Mode fault pulse |
| crc_err_i | input | 1 | CRC mismatch pulse |
| sck_edge_i | input | 1 | Serial clock sampling edge pulse |
| halt_i | input | 1 | System is in halt mode |
| slave_i | input | 1 | Peripheral configured as slave |
| irq_o | output | 1 | Interrupt request level |
| wake_o | output | 1 | Wake-from-halt request |

## Verification
The assertions assume that every event input is a clean, synchronous pulse and that `addr_i` stays on a defined value whenever `wr_i` is high. They do not assume that events are mutually exclusive. A set can coincide with a clearing write or a load, and the properties state which of them wins. The stimulus drives each pulse for one cycle from the falling edge. It also puts sets and clears into the same cycle on purpose, so that the ordering properties are exercised and not only the quiet paths.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    parameter int unsigned STICKY_N = 4;
    parameter int unsigned EN_N     = 4;

    // sticky flag index order inside the bank
    localparam int unsigned IX_WKUP = 0;
    localparam int unsigned IX_CRC  = 1;
    localparam int unsigned IX_MODF = 2;
    localparam int unsigned IX_OVR  = 3;

    // enable register index order (register bits 7..4)
    localparam int unsigned EN_WK = 0;
    localparam int unsigned EN_ER = 1;
    localparam int unsigned EN_RX = 2;
    localparam int unsigned EN_TX = 3;

    typedef struct packed {
        logic [EN_N-1:0] ien;
        logic            txe;
        logic            rxne;
    } ctl_t;
endpackage

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // set beats a coincident clearing write
        assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[i] |=> flag_q[i]);
        // a set flag persists until an explicit clear
        assert_sticky_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        // a flag only rises after a set pulse
        assert_rise_needs_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(flag_q[i]) |-> $past(set_i[i]));
    end
endmodule

// File: rtl/spi_irq_merge.sv
module spi_irq_merge
    import spi_stat_pkg::*;
(
    input  logic [EN_N-1:0]     ien_i,
    input  logic [STICKY_N-1:0] sticky_i,
    input  logic                txe_i,
    input  logic                rxne_i,
    output logic                irq_o,
    output logic                wake_o
);
    logic err_any, wk_req;

    always_comb begin
        err_any = sticky_i[IX_OVR] | sticky_i[IX_MODF] | sticky_i[IX_CRC];
        wk_req  = sticky_i[IX_WKUP] & ien_i[EN_WK];
        irq_o   = (txe_i & ien_i[EN_TX]) | (rxne_i & ien_i[EN_RX])
                | wk_req | (err_any & ien_i[EN_ER]);
        wake_o  = wk_req;
    end

    // a halt wake request is always also a normal interrupt request
    always_comb begin
        assert_wake_in_irq_R10: assert (!wake_o || irq_o);
    end
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
    import spi_stat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter logic [1:0]  ADDR_STAT = 2'd0,
    parameter logic [1:0]  ADDR_IEN  = 2'd1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              txe_set_i,
    input  logic              tx_load_i,
    input  logic              rx_done_i,
    input  logic              rx_read_i,
    input  logic              ovr_i,
    input  logic              modf_i,
    input  logic              crc_err_i,
    input  logic              sck_edge_i,
    input  logic              halt_i,
    input  logic              slave_i,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int unsigned STICKY_LSB = 3;
    localparam int unsigned STICKY_MSB = STICKY_LSB + STICKY_N - 1;
    localparam int unsigned EN_LSB     = DATA_W - EN_N;

    ctl_t ctl_d, ctl_q;
    logic                wr_stat, wr_ien, wk_evt;
    logic [STICKY_N-1:0] sticky_set, sticky_clr, sticky_q;

    always_comb begin
        wr_stat    = wr_i && (addr_i == ADDR_STAT);
        wr_ien     = wr_i && (addr_i == ADDR_IEN);
        wk_evt     = sck_edge_i & halt_i & slave_i;
        sticky_set = '0;
        sticky_set[IX_OVR]  = ovr_i;
        sticky_set[IX_MODF] = modf_i;
        sticky_set[IX_CRC]  = crc_err_i;
        sticky_set[IX_WKUP] = wk_evt;
        sticky_clr = {STICKY_N{wr_stat}} & ~wdata_i[STICKY_MSB:STICKY_LSB];

        ctl_d = ctl_q;
        if (wr_ien)    ctl_d.ien  = wdata_i[DATA_W-1:EN_LSB];
        if (tx_load_i) ctl_d.txe  = 1'b0;
        if (txe_set_i) ctl_d.txe  = 1'b1;
        if (rx_read_i) ctl_d.rxne = 1'b0;
        if (rx_done_i) ctl_d.rxne = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '{ien: '0, txe: 1'b1, rxne: 1'b0};
        else         ctl_q <= ctl_d;
    end

    spi_flag_bank #(.N(STICKY_N)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (sticky_set),
        .clr_i  (sticky_clr),
        .flag_o (sticky_q)
    );

    spi_irq_merge u_merge (
        .ien_i    (ctl_q.ien),
        .sticky_i (sticky_q),
        .txe_i    (ctl_q.txe),
        .rxne_i   (ctl_q.rxne),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_STAT)
            rdata_o = {busy_i, sticky_q, 1'b0, ctl_q.txe, ctl_q.rxne};
        else if (addr_i == ADDR_IEN)
            rdata_o[DATA_W-1:EN_LSB] = ctl_q.ien;
    end

    assert_wkup_qualified_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sticky_q[IX_WKUP]) |-> $past(sck_edge_i && halt_i && slave_i));
    assert_txe_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!txe_set_i && !tx_load_i) |=> $stable(ctl_q.txe));
    assert_rxne_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rx_done_i && !rx_read_i) |=> $stable(ctl_q.rxne));
    assert_txe_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txe_set_i |=> ctl_q.txe);
    assert_rxne_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_i |=> ctl_q.rxne);
    assert_ien_low_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == ADDR_IEN) |-> (rdata_o[EN_LSB-1:0] == '0));
    assert_ien_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_ien |=> $stable(ctl_q.ien));
    assert_reserved_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == ADDR_STAT) |-> !rdata_o[2]);
endmodule

// File: tb/spi_stat_irq_tb.sv
module spi_stat_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic busy = 0, txe_set = 0, tx_load = 0, rx_done = 0, rx_read = 0;
    logic ovr = 0, modf = 0, crc = 0, sck = 0, halt = 0, slave = 0;
    logic irq, wake;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    spi_stat_irq u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .busy_i(busy), .txe_set_i(txe_set), .tx_load_i(tx_load),
        .rx_done_i(rx_done), .rx_read_i(rx_read), .ovr_i(ovr), .modf_i(modf),
        .crc_err_i(crc), .sck_edge_i(sck), .halt_i(halt), .slave_i(slave),
        .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // clear all sticky flags, drain rx, reload tx, disable interrupts
    task automatic clean();
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h00);
        @(negedge clk); tx_load = 1; rx_read = 1;
        @(negedge clk); tx_load = 0; rx_read = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 status", v, 8'h02);
        rd(2'd1, v); chk("R1 enable", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 wake", {7'd0, wake}, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        clean();
        @(negedge clk); ovr = 1;
        @(negedge clk); ovr = 0; modf = 1;
        @(negedge clk); modf = 0; crc = 1;
        @(negedge clk); crc = 0;
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R2 errors sticky", v & 8'h70, 8'h70);
    endtask

    task automatic t_w0c();
        logic [7:0] v;
        // flags 6,5,4 set; clear only modf (bit5) by writing 0 there
        wr_reg(2'd0, 8'hDF);
        rd(2'd0, v); chk("R3 clear modf only", v & 8'h78, 8'h50);
        wr_reg(2'd0, 8'hFF);
        rd(2'd0, v); chk("R3 ones keep", v & 8'h78, 8'h50);
        wr_reg(2'd0, 8'h00);
        rd(2'd0, v); chk("R3 zeros clear", v & 8'h78, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        clean();
        @(negedge clk); addr = 2'd0; wdata = 8'h00; wr = 1; crc = 1;
        @(negedge clk); wr = 0; crc = 0;
        rd(2'd0, v); chk("R4 set beats clear", v & 8'h10, 8'h10);
        wr_reg(2'd0, 8'h00);
    endtask

    task automatic t_wakeup();
        logic [7:0] v;
        clean();
        @(negedge clk); sck = 1; halt = 0; slave = 1;
        @(negedge clk); sck = 0;
        rd(2'd0, v); chk("R5 not halted", v & 8'h08, 8'h00);
        @(negedge clk); sck = 1; halt = 1; slave = 0;
        @(negedge clk); sck = 0;
        rd(2'd0, v); chk("R5 master", v & 8'h08, 8'h00);
        @(negedge clk); sck = 1; halt = 1; slave = 1;
        @(negedge clk); sck = 0; halt = 0; slave = 0;
        rd(2'd0, v); chk("R5 slave halted", v & 8'h08, 8'h08);
        wr_reg(2'd0, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        clean();
        @(negedge clk); rx_done = 1;
        @(negedge clk); rx_done = 0;
        wr_reg(2'd0, 8'h04);
        busy = 1;
        rd(2'd0, v); chk("R6 ro bits keep", v, 8'h81);
        wr_reg(2'd0, 8'hFF);
        busy = 0;
        rd(2'd0, v); chk("R6 ones no set", v, 8'h01);
    endtask

    task automatic t_txrx();
        logic [7:0] v;
        clean();
        rd(2'd0, v); chk("R7 both empty", v & 8'h03, 8'h00);
        @(negedge clk); txe_set = 1; rx_done = 1;
        @(negedge clk); txe_set = 0; rx_done = 0;
        rd(2'd0, v); chk("R7 both set", v & 8'h03, 8'h03);
        @(negedge clk); txe_set = 1; tx_load = 1; rx_done = 1; rx_read = 1;
        @(negedge clk); txe_set = 0; tx_load = 0; rx_done = 0; rx_read = 0;
        rd(2'd0, v); chk("R7 set wins", v & 8'h03, 8'h03);
        @(negedge clk); rx_read = 1;
        @(negedge clk); rx_read = 0;
        rd(2'd0, v); chk("R7 rx read", v & 8'h03, 8'h02);
    endtask

    task automatic t_ien();
        logic [7:0] v;
        wr_reg(2'd1, 8'hAF);
        rd(2'd1, v); chk("R8 enable store", v, 8'hA0);
        wr_reg(2'd1, 8'h5F);
        rd(2'd1, v); chk("R8 enable rewrite", v, 8'h50);
        wr_reg(2'd1, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        clean();
        wr_reg(2'd1, 8'hF0);
        rd(2'd0, v); chk("R9 idle no irq", {7'd0, irq}, 8'h00);
        @(negedge clk); txe_set = 1;
        @(negedge clk); txe_set = 0;
        #1 chk("R9 tx irq", {7'd0, irq}, 8'h01);
        wr_reg(2'd1, 8'h70);
        #1 chk("R9 tx masked", {7'd0, irq}, 8'h00);
        @(negedge clk); modf = 1;
        @(negedge clk); modf = 0;
        #1 chk("R9 err irq", {7'd0, irq}, 8'h01);
        wr_reg(2'd1, 8'h50);
        #1 chk("R9 err masked", {7'd0, irq}, 8'h00);
        wr_reg(2'd1, 8'h70);
        wr_reg(2'd0, 8'h00);
        #1 chk("R9 err cleared", {7'd0, irq}, 8'h00);
        @(negedge clk); rx_done = 1;
        @(negedge clk); rx_done = 0;
        #1 chk("R9 rx irq", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_wake();
        clean();
        wr_reg(2'd1, 8'hF0);
        @(negedge clk); ovr = 1; txe_set = 1; rx_done = 1;
        @(negedge clk); ovr = 0; txe_set = 0; rx_done = 0;
        #1 chk("R10 no wake from others", {7'd0, wake}, 8'h00);
        @(negedge clk); sck = 1; halt = 1; slave = 1;
        @(negedge clk); sck = 0; halt = 0; slave = 0;
        #1 chk("R10 wake", {7'd0, wake}, 8'h01);
        wr_reg(2'd1, 8'hE0);
        #1 chk("R10 wake masked", {7'd0, wake}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sticky();
        t_w0c();
        t_collision();
        t_wakeup();
        t_readonly();
        t_txrx();
        t_ien();
        t_irq();
        t_wake();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule